// File: doc/BRIEF.md
# Flash command and protection controller

This block is the command front end of a block-organised flash device. It decodes two-write command sequences arriving on a plain bus-write strobe. The sequences cover four operations: loading a configuration word, locking one block against modification, releasing the locks of every block at once, and programming a one-time-programmable (OTP) protection area. Every write is taken in the cycle it is presented, so the write strobe has no back-pressure. A write made while the block is busy is dropped on purpose; it is not stalled.

A fixed-latency busy counter stands in for the program/erase engine. While it runs, the ready flag is low and only the read-status code has any effect. The block's effect on its storage (block lock bits, the 64-bit OTP user area, and the two OTP lock bits) is committed on the cycle the busy phase ends. These contents are treated as non-volatile. Only the power-on input initialises them. The soft reset clears the command state, the configuration word and the error flags, and it abandons an operation in flight.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After power-on reset: status = 0x80, status_mode = 0, cfg_reg = 0, blk_lock = 0, otp_user = all ones, otp_lock = 2'b10, ready = 1.
- R2: A write of 0x60 followed by a write of 0x03 (command codes are wr_data[7:0]) loads cfg_reg from wr_addr[16:1], with bit 0 of cfg_reg taken from wr_addr[1]. Other address bits are ignored. status_mode returns to 0 and ready stays 1.
- R3: 0x60 then 0x01 selects block wr_addr[ADDR_W-1 -: BLK_W] of the second write. status_mode becomes 1 and ready is low for exactly BUSY_CYC cycles. The block's lock bit is set when ready returns, and not before.
- R4: 0x60 then 0xD0 clears every blk_lock bit when its busy phase ends. Its busy phase is also BUSY_CYC cycles.
- R5: While ready is low, every write is ignored except 0x70, which selects status output. The same holds for a write sampled in the last busy cycle.
- R6: Status layout: bit 7 = ready, bit 5 = command-sequence error, bit 4 = programming error, all other bits 0. The error bits stay set until a soft reset.
- R7: After 0x60, any second code other than 0x01, 0x03 or 0xD0 sets status bit 5 and status_mode. No busy phase starts and no storage changes.
- R8: 0xC0 followed by a write to word index wr_addr[2:0] = 4..7 stores wr_data into otp_user[16*(idx-4) +: 16] at the end of a BUSY_CYC busy phase. This applies while otp_lock[1] is 1.
- R9: 0xC0 followed by a write to index 0 programs the lock bits: otp_lock becomes otp_lock & wr_data[1:0]. A lock bit at 0 never returns to 1, even across soft reset. Bit 0 (the factory area lock) is always 0.
- R10: An OTP program to index 1..3 (the factory area), or to 4..7 once otp_lock[1] = 0, sets status bit 4 and status_mode. It starts no busy phase and leaves otp_user unchanged.
- R11: Soft reset (rst_n low) clears cfg_reg, the error bits and status_mode, and abandons a running operation so that its effect is never committed. blk_lock, otp_user and otp_lock keep their values.
- R12: A first write whose code is not 0x60, 0xC0 or 0x70 has no effect on status, status_mode or later decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, initialises non-volatile contents |
| rst_n | input | 1 | Soft reset, active low |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 16 | Write data; command codes in bits 7:0 |
| ready | output | 1 | High when no operation is running |
| status | output | 8 | Status register |
| status_mode | output | 1 | 1 = reads return status, 0 = array read |
| cfg_reg | output | 16 | Configuration word |
| blk_lock | output | NBLK | Per-block lock bits |
| otp_user | output | 64 | OTP user area |
| otp_lock | output | 2 | OTP lock bits (bit 1 user, bit 0 factory) |

## Verification
The busy phase can end in the same cycle that a new write arrives. The design must then treat the write as belonging to the busy period, not as the first cycle of a new command. The bench starts a block lock and places a 0x60 write exactly on the cycle the counter reaches zero. It then writes 0x03 and judges that cfg_reg is unchanged, which is only true if the 0x60 was dropped. The complementary case sends the same sequence in the first ready cycle and expects cfg_reg to load.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  localparam logic [7:0] OP_SETUP   = 8'h60;
  localparam logic [7:0] OP_OTP     = 8'hC0;
  localparam logic [7:0] OP_RDSR    = 8'h70;
  localparam logic [7:0] SUB_CFG    = 8'h03;
  localparam logic [7:0] SUB_PROT   = 8'h01;
  localparam logic [7:0] SUB_UNPROT = 8'hD0;

  localparam int SR_RDY = 7;
  localparam int SR_SEQ = 5;
  localparam int SR_PRG = 4;

  typedef enum logic [1:0] {
    DS_IDLE,
    DS_SETUP,
    DS_OTP
  } dec_state_e;

  typedef enum logic [1:0] {
    JOB_NONE,
    JOB_PROT,
    JOB_UNPROT,
    JOB_OTP
  } job_e;
endpackage

// File: rtl/fcc_busy_timer.sv
module fcc_busy_timer #(
  parameter int BUSY_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= CNT_W'(BUSY_CYC);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);
  // the commit edge is the one that takes the count from 1 to 0
  assign done = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/fcc_decoder.sv
module fcc_decoder
  import fcc_pkg::*;
#(
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       opcode,
  input  logic [CFG_W-1:0] cfg_bits,
  input  logic [2:0]       otp_idx,
  input  logic             busy,
  input  logic             user_locked,
  output logic             start,
  output job_e             job,
  output logic [CFG_W-1:0] cfg_reg,
  output logic             status_mode,
  output logic             seq_err,
  output logic             prg_err
);
  dec_state_e state_q;
  logic       take;

  assign take = wr_en && !busy;

  // second-cycle decode that launches the busy phase
  always_comb begin
    start = 1'b0;
    job   = JOB_NONE;
    if (take) begin
      case (state_q)
        DS_SETUP: begin
          if (opcode == SUB_PROT) begin
            start = 1'b1;
            job   = JOB_PROT;
          end else if (opcode == SUB_UNPROT) begin
            start = 1'b1;
            job   = JOB_UNPROT;
          end
        end
        DS_OTP: begin
          if (otp_idx == 3'd0 || (otp_idx[2] && !user_locked)) begin
            start = 1'b1;
            job   = JOB_OTP;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= DS_IDLE;
      cfg_reg     <= '0;
      status_mode <= 1'b0;
      seq_err     <= 1'b0;
      prg_err     <= 1'b0;
    end else if (wr_en && busy) begin
      if (opcode == OP_RDSR) status_mode <= 1'b1;
    end else if (take) begin
      case (state_q)
        DS_IDLE: begin
          if (opcode == OP_SETUP)     state_q <= DS_SETUP;
          else if (opcode == OP_OTP)  state_q <= DS_OTP;
          else if (opcode == OP_RDSR) status_mode <= 1'b1;
        end
        DS_SETUP: begin
          state_q <= DS_IDLE;
          if (opcode == SUB_CFG) begin
            cfg_reg     <= cfg_bits;
            status_mode <= 1'b0;
          end else begin
            status_mode <= 1'b1;
            if (!start) seq_err <= 1'b1;
          end
        end
        DS_OTP: begin
          state_q     <= DS_IDLE;
          status_mode <= 1'b1;
          if (!start) prg_err <= 1'b1;
        end
        default: state_q <= DS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fcc_nv_store.sv
module fcc_nv_store
  import fcc_pkg::*;
#(
  parameter int NBLK   = 8,
  parameter int DATA_W = 16,
  parameter int OTP_W  = 64
) (
  input  logic                    clk,
  input  logic                    por_n,
  input  logic                    start,
  input  job_e                    job,
  input  logic [$clog2(NBLK)-1:0] blk_sel,
  input  logic [2:0]              otp_idx,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    done,
  output logic [NBLK-1:0]         blk_lock,
  output logic [OTP_W-1:0]        otp_user,
  output logic [1:0]              otp_lock
);
  localparam int BLK_W     = $clog2(NBLK);
  localparam int OTP_WORDS = OTP_W / DATA_W;

  job_e              job_q;
  logic [BLK_W-1:0]  blk_q;
  logic [2:0]        idx_q;
  logic [DATA_W-1:0] data_q;

  // operands held for the whole busy phase
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      job_q  <= JOB_NONE;
      blk_q  <= '0;
      idx_q  <= '0;
      data_q <= '0;
    end else if (start) begin
      job_q  <= job;
      blk_q  <= blk_sel;
      idx_q  <= otp_idx;
      data_q <= wr_data;
    end
  end

  for (genvar gb = 0; gb < NBLK; gb++) begin : g_blk
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
        blk_lock[gb] <= 1'b0;
      end else if (done) begin
        if (job_q == JOB_UNPROT) blk_lock[gb] <= 1'b0;
        else if (job_q == JOB_PROT && blk_q == BLK_W'(gb)) blk_lock[gb] <= 1'b1;
      end
    end
  end

  for (genvar gw = 0; gw < OTP_WORDS; gw++) begin : g_word
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
        otp_user[gw*DATA_W +: DATA_W] <= '1;
      end else if (done && job_q == JOB_OTP && idx_q[2] && idx_q[1:0] == 2'(gw)) begin
        otp_user[gw*DATA_W +: DATA_W] <= data_q;
      end
    end
  end

  // lock bits can only be programmed towards zero
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      otp_lock <= 2'b10;
    end else if (done && job_q == JOB_OTP && idx_q == 3'd0) begin
      otp_lock <= otp_lock & data_q[1:0];
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int NBLK     = 8,
  parameter int BUSY_CYC = 4,
  parameter int ADDR_W   = 20
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  output logic              ready,
  output logic [7:0]        status,
  output logic              status_mode,
  output logic [15:0]       cfg_reg,
  output logic [NBLK-1:0]   blk_lock,
  output logic [63:0]       otp_user,
  output logic [1:0]        otp_lock
);
  localparam int BLK_W = $clog2(NBLK);
  localparam int CFG_W = 16;

  logic ctl_rst_n;
  logic start, busy, done, seq_err, prg_err;
  job_e job;

  assign ctl_rst_n = rst_n & por_n;

  fcc_decoder #(.CFG_W(CFG_W)) u_dec (
    .clk        (clk),
    .rst_n      (ctl_rst_n),
    .wr_en      (wr_en),
    .opcode     (wr_data[7:0]),
    .cfg_bits   (wr_addr[CFG_W:1]),
    .otp_idx    (wr_addr[2:0]),
    .busy       (busy),
    .user_locked(!otp_lock[1]),
    .start      (start),
    .job        (job),
    .cfg_reg    (cfg_reg),
    .status_mode(status_mode),
    .seq_err    (seq_err),
    .prg_err    (prg_err)
  );

  fcc_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_tmr (
    .clk  (clk),
    .rst_n(ctl_rst_n),
    .start(start),
    .busy (busy),
    .done (done)
  );

  fcc_nv_store #(.NBLK(NBLK), .DATA_W(16), .OTP_W(64)) u_nv (
    .clk     (clk),
    .por_n   (por_n),
    .start   (start),
    .job     (job),
    .blk_sel (wr_addr[ADDR_W-1 -: BLK_W]),
    .otp_idx (wr_addr[2:0]),
    .wr_data (wr_data),
    .done    (done),
    .blk_lock(blk_lock),
    .otp_user(otp_user),
    .otp_lock(otp_lock)
  );

  assign ready = !busy;

  always_comb begin
    status         = '0;
    status[SR_RDY] = ready;
    status[SR_SEQ] = seq_err;
    status[SR_PRG] = prg_err;
  end
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
  parameter int NBLK     = 8,
  parameter int BUSY_CYC = 4
) (
  input logic            clk,
  input logic            por_n,
  input logic            rst_n,
  input logic            ready,
  input logic            status_mode,
  input logic [15:0]     cfg_reg,
  input logic [NBLK-1:0] blk_lock,
  input logic [63:0]     otp_user,
  input logic [1:0]      otp_lock
);
  localparam int RUN_W = $clog2(BUSY_CYC + 2);

  logic             any_rst_n;
  logic [RUN_W-1:0] low_run;

  assign any_rst_n = rst_n & por_n;

  always_ff @(posedge clk or negedge any_rst_n) begin
    if (!any_rst_n)  low_run <= '0;
    else if (!ready) low_run <= low_run + 1'b1;
    else             low_run <= '0;
  end

  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (!any_rst_n)
    low_run <= RUN_W'(BUSY_CYC));

  // R5
  busy_status_chk: assert property (@(posedge clk) disable iff (!any_rst_n)
    !ready |-> status_mode);

  // R4
  blk_commit_chk: assert property (@(posedge clk) disable iff (!por_n)
    (blk_lock != $past(blk_lock)) |-> $rose(ready));

  // R9
  lock_mono_chk: assert property (@(posedge clk) disable iff (!por_n)
    (otp_lock & ~$past(otp_lock)) == 2'b00);

  // R9
  factory_lock_chk: assert property (@(posedge clk) disable iff (!por_n)
    otp_lock[0] == 1'b0);

  // R10
  otp_frozen_chk: assert property (@(posedge clk) disable iff (!por_n)
    !$past(otp_lock[1]) |-> $stable(otp_user));

  // R2
  cfg_mode_chk: assert property (@(posedge clk) disable iff (!any_rst_n)
    (cfg_reg != $past(cfg_reg)) |-> (!status_mode && ready));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.NBLK(NBLK), .BUSY_CYC(BUSY_CYC)) u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .rst_n      (rst_n),
  .ready      (ready),
  .status_mode(status_mode),
  .cfg_reg    (cfg_reg),
  .blk_lock   (blk_lock),
  .otp_user   (otp_user),
  .otp_lock   (otp_lock)
);

// File: tb/tb_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_flash_cmd_ctrl;
  localparam int NBLK = 8;
  localparam int BCYC = 3;
  localparam int AW   = 20;

  logic          clk = 1'b0;
  logic          por_n, rst_n, wr_en;
  logic [AW-1:0] wr_addr;
  logic [15:0]   wr_data;
  logic          ready, status_mode;
  logic [7:0]    status;
  logic [15:0]   cfg_reg;
  logic [NBLK-1:0] blk_lock;
  logic [63:0]   otp_user;
  logic [1:0]    otp_lock;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  logic [NBLK-1:0] e_lock;
  logic [63:0]     e_user;
  logic [1:0]      e_olock;
  logic [15:0]     e_cfg;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(.NBLK(NBLK), .BUSY_CYC(BCYC), .ADDR_W(AW)) dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .ready(ready), .status(status),
    .status_mode(status_mode), .cfg_reg(cfg_reg), .blk_lock(blk_lock),
    .otp_user(otp_user), .otp_lock(otp_lock)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // starts and ends on a falling edge; the write is sampled at the rising edge in between
  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic soft_reset();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    e_cfg = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    por_n = 1'b0; rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    e_lock = '0; e_user = '1; e_olock = 2'b10; e_cfg = '0;

    // R1 reset state
    chk("R1 status", status, 64'h80);
    chk("R1 mode", status_mode, 0);
    chk("R1 cfg", cfg_reg, 0);
    chk("R1 blk", blk_lock, 0);
    chk("R1 otp", otp_user, e_user);
    chk("R1 lock", otp_lock, 2'b10);

    // R2 walking-one configuration sweep with junk in ignored address bits
    for (int i = 0; i < 16; i++) begin
      wr('0, 16'h0070);
      wr('0, 16'h0060);
      wr((20'h1 << (i + 1)) | 20'hE0001, 16'hAB03);
      e_cfg = 16'h1 << i;
      chk("R2 cfg", cfg_reg, e_cfg);
      chk("R2 mode/ready", {status_mode, ready}, 2'b01);
    end

    // R3 lock each block in turn
    for (int b = 0; b < NBLK; b++) begin
      wr('0, 16'h0060);
      wr((AW'(b) << 17) | 20'h05A5A, 16'h0001);
      chk("R3 mode", status_mode, 1);
      chk("R3 not yet", blk_lock, e_lock);
      wait_ready(n);
      chk("R3 busy len", n, BCYC);
      e_lock[b] = 1'b1;
      chk("R3 blk", blk_lock, e_lock);
    end

    // R4 global release
    wr('0, 16'h0060);
    wr(20'hA0000, 16'h00D0);
    wait_ready(n);
    chk("R4 busy len", n, BCYC);
    e_lock = '0;
    chk("R4 blk", blk_lock, e_lock);

    // R5 writes during busy are dropped except read-status
    wr('0, 16'h0060);
    wr(20'h40000, 16'h0001);
    wr('0, 16'h0060);
    wr(20'h02468, 16'h0003);
    wr('0, 16'h0070);
    e_lock[2] = 1'b1;
    chk("R5 blk", blk_lock, e_lock);
    chk("R5 cfg", cfg_reg, e_cfg);
    chk("R5 mode", status_mode, 1);
    wr('0, 16'h00D0);
    chk("R5 no setup left", blk_lock, e_lock);
    chk("R6 status clean", status, 64'h80);

    // R5 write in the last busy cycle is dropped
    wr('0, 16'h0060);
    wr(20'hA0000, 16'h0001);
    @(negedge clk);
    @(negedge clk);
    wr('0, 16'h0060);
    chk("R5 ready after last", ready, 1);
    wr(20'h02468, 16'h0003);
    e_lock[5] = 1'b1;
    chk("R5 last-cycle cfg", cfg_reg, e_cfg);
    chk("R5 last-cycle blk", blk_lock, e_lock);

    // first ready cycle accepts a new command
    wr('0, 16'h0060);
    wr(20'hC0000, 16'h0001);
    wait_ready(n);
    wr('0, 16'h0060);
    wr(20'h00084, 16'h0003);
    e_lock[6] = 1'b1;
    e_cfg = 16'h0042;
    chk("R2 first-ready cfg", cfg_reg, e_cfg);
    chk("R3 first-ready blk", blk_lock, e_lock);

    // R12 unknown first codes are ignored
    for (int c = 0; c < 256; c++) begin
      if (c == 8'h60 || c == 8'hC0 || c == 8'h70) continue;
      wr(20'hFFFFF, 16'(c));
      chk("R12 status/mode", {status, status_mode}, {8'h80, 1'b0});
    end
    chk("R12 cfg", cfg_reg, e_cfg);

    // R7 bad second codes, each cleared by soft reset
    for (int c = 0; c < 256; c++) begin
      if (c == 8'h01 || c == 8'h03 || c == 8'hD0) continue;
      wr('0, 16'h0060);
      wr(20'h20000, 16'(c));
      chk("R7 status/mode", {status, status_mode}, {8'hA0, 1'b1});
      chk("R7 blk", blk_lock, e_lock);
      soft_reset();
      chk("R11 status cleared", {status, status_mode}, {8'h80, 1'b0});
    end
    chk("R11 cfg cleared", cfg_reg, e_cfg);

    // R8 program each user word
    for (int w = 0; w < 4; w++) begin
      logic [15:0] d;
      d = 16'hA5A0 ^ 16'(w * 16'h1111);
      wr('0, 16'h00C0);
      wr(AW'(4 + w), d);
      chk("R8 not yet", otp_user, e_user);
      wait_ready(n);
      chk("R8 busy len", n, BCYC);
      e_user[w*16 +: 16] = d;
      chk("R8 otp", otp_user, e_user);
      chk("R8 status", status, 64'h80);
    end

    // R11 soft reset abandons a running lock
    wr('0, 16'h0060);
    wr(20'h00000, 16'h0001);
    soft_reset();
    chk("R11 ready", ready, 1);
    repeat (BCYC + 2) @(negedge clk);
    chk("R11 blk kept", blk_lock, e_lock);
    chk("R11 otp kept", otp_user, e_user);

    // R10 factory area is always locked
    wr('0, 16'h00C0);
    wr(20'h00001, 16'h1234);
    chk("R10 factory status", status, 64'h90);
    chk("R10 factory mode", status_mode, 1);
    chk("R10 factory otp", otp_user, e_user);
    soft_reset();

    // R9 lock the user area
    wr('0, 16'h00C0);
    wr(20'h00000, 16'hFFFD);
    wait_ready(n);
    e_olock = 2'b00;
    chk("R9 lock", otp_lock, e_olock);

    // R10 programming a locked user word
    wr('0, 16'h00C0);
    wr(20'h00005, 16'h0000);
    chk("R10 locked status", status, 64'h90);
    chk("R10 locked otp", otp_user, e_user);
    soft_reset();

    // R9 locks survive soft reset and cannot be raised again
    chk("R9 lock after reset", otp_lock, e_olock);
    wr('0, 16'h00C0);
    wr(20'h00000, 16'hFFFF);
    wait_ready(n);
    chk("R9 lock irreversible", otp_lock, e_olock);
    chk("R11 blk survives", blk_lock, e_lock);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule